// File: doc/BRIEF.md
# Programmable Four-Requester Priority Arbiter

This block decides which of four agents may use the shared external memory bus next. The four agents are the receive DMA engine, the host microprocessor, the transmit DMA engine and the interrupt controller. Each agent raises its own request line. The arbiter answers with a one-hot grant. It holds that grant until the memory controller reports that the current access has finished.

The order of the agents is not fixed. It comes from an 8-bit priority field made of four 2-bit slots. Each slot names one agent by its code. The field is the upper byte of a 16-bit memory configuration word, which is written through a simple write port. The lower byte of that word holds the memory timing bits. The arbiter stores them and presents them to the memory cycle generator. When several requests are pending, the agent named in the best slot wins. Agents that no slot names rank below all named agents.

Top module: `mbus_prio_arbiter`

## Requirements
- R1: After reset the grant is 0, the timing output reads 0xF0 and the priority field is 0xE4, giving the full configuration word 0xE4F0.
- R2: Request and grant bit i belong to agent code i: code 0 is receive DMA, 1 is microprocessor, 2 is transmit DMA and 3 is interrupt controller. With the reset field and all four pending, the order is code 0, then 1, then 2, then 3.
- R3: Priority bits [1:0] name the agent at rank 1 (highest), [3:2] rank 2, [5:4] rank 3 and [7:6] rank 4. Among pending agents, the one in the lowest-numbered rank is granted.
- R4: The grant has at most one bit set, and a new grant goes only to an agent whose request was high on the deciding clock edge.
- R5: While a grant is active and acc_done is low, the grant stays unchanged, whatever the request lines do.
- R6: A clock edge that sees acc_done high while a grant is active clears the grant. The next edge that sees any request pending issues a new grant.
- R7: If one code appears in several slots, only its best (lowest-numbered) slot counts.
- R8: Agents named in no slot rank below every named agent. Ties among them go to the lower code.
- R9: A priority write made while a grant is active leaves that grant untouched and takes effect at the next decision.
- R10: A clock edge with cfg_wr_en high loads cfg_wr_data. Bits [15:8] become the priority field and bits [7:0] the timing output, both visible after that edge.
- R11: acc_done is ignored while no grant is active. With no request pending the grant stays 0, and a later grant is not cut short by an earlier idle acc_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 4 | Request per agent, bit index = agent code |
| acc_done | input | 1 | Current memory access has completed |
| cfg_wr_en | input | 1 | Load the configuration word |
| cfg_wr_data | input | 16 | New configuration word: priority field [15:8], timing [7:0] |
| grant | output | 4 | One-hot bus grant, bit index = agent code |
| cfg_timing | output | 8 | Stored memory timing bits |

## Verification
The bench builds the arbiter with its default parameters: four agents, 2-bit codes and the 0xE4F0 reset word. At that size every code, every slot and every mix of pending requests is within reach of directed stimulus. The bench covers the default ranking, a reversed ranking, a field with a repeated code, and a field in which all four slots name the same agent. It also exercises the handoff timing around acc_done, and a priority write landing in the middle of an active grant.

// File: rtl/mbarb_pkg.sv
package mbarb_pkg;

    localparam int unsigned REQ_NUM  = 4;
    localparam int unsigned CODE_W   = $clog2(REQ_NUM);
    localparam int unsigned PRIO_W   = REQ_NUM * CODE_W;
    localparam int unsigned TIMING_W = 8;
    localparam int unsigned CFG_W    = PRIO_W + TIMING_W;
    localparam int unsigned RANK_W   = $clog2(2 * REQ_NUM);

    typedef struct packed {
        logic [PRIO_W-1:0]   prio;
        logic [TIMING_W-1:0] timing;
    } mem_cfg_t;

    localparam mem_cfg_t CFG_RESET_DEFAULT = '{prio: 8'hE4, timing: 8'hF0};

    typedef enum logic {
        ARB_IDLE  = 1'b0,
        ARB_OWNED = 1'b1
    } arb_state_e;

    typedef struct packed {
        logic              valid;
        logic [CODE_W-1:0] code;
    } arb_pick_t;

    function automatic logic [REQ_NUM-1:0] code_to_onehot(input logic [CODE_W-1:0] code);
        logic [REQ_NUM-1:0] v;
        v = '0;
        v[code] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/mbarb_cfg_reg.sv
module mbarb_cfg_reg
    import mbarb_pkg::*;
#(
    parameter mem_cfg_t RESET_VAL = CFG_RESET_DEFAULT
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [CFG_W-1:0] wr_data,
    output mem_cfg_t        cfg
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= RESET_VAL;
        end else if (wr_en) begin
            cfg <= mem_cfg_t'(wr_data);
        end
    end

endmodule

// File: rtl/mbarb_rank_map.sv
module mbarb_rank_map
    import mbarb_pkg::*;
(
    input  logic [PRIO_W-1:0]              prio,
    output logic [REQ_NUM-1:0][RANK_W-1:0] rank
);

    // Each agent takes the lowest slot index that names it. An agent that no
    // slot names gets REQ_NUM + code, which puts it below every named agent
    // and orders unnamed agents by ascending code.
    for (genvar c = 0; c < REQ_NUM; c++) begin : g_agent
        always_comb begin
            rank[c] = RANK_W'(REQ_NUM + c);
            for (int s = REQ_NUM - 1; s >= 0; s--) begin
                if (prio[s*CODE_W +: CODE_W] == CODE_W'(c)) begin
                    rank[c] = RANK_W'(s);
                end
            end
        end
    end

endmodule

// File: rtl/mbarb_pick.sv
module mbarb_pick
    import mbarb_pkg::*;
(
    input  logic [REQ_NUM-1:0]             req,
    input  logic [REQ_NUM-1:0][RANK_W-1:0] rank,
    output arb_pick_t                      pick
);

    logic [RANK_W-1:0] best;

    always_comb begin
        pick = '0;
        best = '1;
        for (int c = 0; c < REQ_NUM; c++) begin
            if (req[c] && (!pick.valid || rank[c] < best)) begin
                pick.valid = 1'b1;
                pick.code  = CODE_W'(c);
                best       = rank[c];
            end
        end
    end

endmodule

// File: rtl/mbus_prio_arbiter.sv
module mbus_prio_arbiter
    import mbarb_pkg::*;
#(
    parameter mem_cfg_t CFG_RESET_VAL = CFG_RESET_DEFAULT
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [REQ_NUM-1:0]  req,
    input  logic                acc_done,
    input  logic                cfg_wr_en,
    input  logic [CFG_W-1:0]    cfg_wr_data,
    output logic [REQ_NUM-1:0]  grant,
    output logic [TIMING_W-1:0] cfg_timing
);

    mem_cfg_t                       cfg_q;
    logic [REQ_NUM-1:0][RANK_W-1:0] rank;
    arb_pick_t                      pick;
    arb_state_e                     state_q;

    mbarb_cfg_reg #(
        .RESET_VAL (CFG_RESET_VAL)
    ) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_wr_en),
        .wr_data (cfg_wr_data),
        .cfg     (cfg_q)
    );

    mbarb_rank_map u_rank (
        .prio (cfg_q.prio),
        .rank (rank)
    );

    mbarb_pick u_pick (
        .req  (req),
        .rank (rank),
        .pick (pick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ARB_IDLE;
            grant   <= '0;
        end else begin
            unique case (state_q)
                ARB_IDLE: begin
                    if (pick.valid) begin
                        grant   <= code_to_onehot(pick.code);
                        state_q <= ARB_OWNED;
                    end
                end
                ARB_OWNED: begin
                    if (acc_done) begin
                        grant   <= '0;
                        state_q <= ARB_IDLE;
                    end
                end
                default: begin
                    grant   <= '0;
                    state_q <= ARB_IDLE;
                end
            endcase
        end
    end

    assign cfg_timing = cfg_q.timing;

endmodule

// File: rtl/mbarb_checker.sv
module mbarb_checker
    import mbarb_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic [REQ_NUM-1:0] req,
    input logic               acc_done,
    input logic [REQ_NUM-1:0] grant
);

    // R4
    grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    // R4
    grant_to_requester_chk: assert property (@(posedge clk) disable iff (rst)
        (grant == '0 && req != '0) |=> ((grant & $past(req)) != '0));

    // R5
    grant_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (grant != '0 && !acc_done) |=> $stable(grant));

    // R6
    grant_release_chk: assert property (@(posedge clk) disable iff (rst)
        (grant != '0 && acc_done) |=> (grant == '0));

    // R11
    idle_stays_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (grant == '0 && req == '0) |=> (grant == '0));

endmodule

bind mbus_prio_arbiter mbarb_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .req      (req),
    .acc_done (acc_done),
    .grant    (grant)
);

// File: tb/mbus_prio_arbiter_test.sv
`timescale 1ns/1ps
module mbus_prio_arbiter_test;

    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  req;
    logic        acc_done;
    logic        cfg_wr_en;
    logic [15:0] cfg_wr_data;
    logic [3:0]  grant;
    logic [7:0]  cfg_timing;

    int checks   = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    mbus_prio_arbiter uut (
        .clk         (clk),
        .rst         (rst),
        .req         (req),
        .acc_done    (acc_done),
        .cfg_wr_en   (cfg_wr_en),
        .cfg_wr_data (cfg_wr_data),
        .grant       (grant),
        .cfg_timing  (cfg_timing)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_cfg(input logic [15:0] data);
        cfg_wr_en   = 1'b1;
        cfg_wr_data = data;
        step();
        cfg_wr_en   = 1'b0;
    endtask

    // one decision: grant appears one edge after req, clears one edge after acc_done
    task automatic arb_once(input logic [3:0] r, input logic [3:0] exp, input string tag);
        req = r;
        acc_done = 1'b0;
        step();
        chk(tag, {12'h0, grant}, {12'h0, exp});
        chk({tag, " onehot R4"}, 16'($countones(grant) <= 1), 16'h1);
        acc_done = 1'b1;
        step();
        chk({tag, " release R6"}, {12'h0, grant}, 16'h0);
        acc_done = 1'b0;
        req = 4'h0;
    endtask

    task automatic t_reset();
        chk("R1 grant after reset", {12'h0, grant}, 16'h0);
        chk("R1 timing after reset", {8'h0, cfg_timing}, 16'h00F0);
    endtask

    task automatic t_default_order();
        arb_once(4'hF, 4'b0001, "R2 all pending -> rx dma");
        arb_once(4'hE, 4'b0010, "R2 -> microprocessor");
        arb_once(4'hC, 4'b0100, "R2 -> tx dma");
        arb_once(4'h8, 4'b1000, "R2 -> interrupt ctrl");
    endtask

    task automatic t_hold();
        req = 4'b0100;
        step();
        chk("R5 initial grant", {12'h0, grant}, 16'h0004);
        req = 4'b0001;
        step();
        chk("R5 held despite higher req", {12'h0, grant}, 16'h0004);
        req = 4'b0000;
        step();
        chk("R5 held with req dropped", {12'h0, grant}, 16'h0004);
        acc_done = 1'b1;
        step();
        chk("R6 cleared on done", {12'h0, grant}, 16'h0);
        acc_done = 1'b0;
        req = 4'b0011;
        step();
        chk("R6 re-arbitrated next edge", {12'h0, grant}, 16'h0001);
        acc_done = 1'b1;
        step();
        acc_done = 1'b0;
        req = 4'h0;
    endtask

    task automatic t_program();
        // slots: rank1=3, rank2=2, rank3=1, rank4=0
        wr_cfg(16'h1B5A);
        chk("R10 timing byte loaded", {8'h0, cfg_timing}, 16'h005A);
        arb_once(4'hF, 4'b1000, "R3 reversed: intr first");
        arb_once(4'b0101, 4'b0100, "R3 reversed: tx over rx");
        arb_once(4'b0011, 4'b0010, "R3 reversed: mpu over rx");
    endtask

    task automatic t_dup();
        // slots: rank1=2, rank2=2, rank3=1, rank4=0; code 3 unnamed
        wr_cfg(16'h1AF0);
        arb_once(4'b1011, 4'b0010, "R7 dup: mpu ahead of rx");
        arb_once(4'b1001, 4'b0001, "R7 dup: rx ahead of unnamed intr");
        arb_once(4'b1100, 4'b0100, "R7 dup: tx best");
    endtask

    task automatic t_unnamed();
        // every slot names code 3
        wr_cfg(16'hFFF0);
        arb_once(4'b1111, 4'b1000, "R8 named intr first");
        arb_once(4'b0111, 4'b0001, "R8 unnamed tie -> code 0");
        arb_once(4'b0110, 4'b0010, "R8 unnamed tie -> code 1");
    endtask

    task automatic t_midwrite();
        wr_cfg(16'hE4F0);
        req = 4'b0011;
        step();
        chk("R9 grant under default", {12'h0, grant}, 16'h0001);
        cfg_wr_en = 1'b1;
        cfg_wr_data = 16'h1BF0;
        step();
        cfg_wr_en = 1'b0;
        chk("R9 grant kept after write", {12'h0, grant}, 16'h0001);
        step();
        chk("R9 grant still kept", {12'h0, grant}, 16'h0001);
        acc_done = 1'b1;
        step();
        acc_done = 1'b0;
        step();
        chk("R9 next decision uses new field", {12'h0, grant}, 16'h0002);
        acc_done = 1'b1;
        step();
        acc_done = 1'b0;
        req = 4'h0;
        wr_cfg(16'hE4F0);
    endtask

    task automatic t_idle_done();
        req = 4'h0;
        acc_done = 1'b1;
        step();
        step();
        chk("R11 idle done no grant", {12'h0, grant}, 16'h0);
        req = 4'b0100;
        acc_done = 1'b0;
        step();
        chk("R11 grant issued", {12'h0, grant}, 16'h0004);
        step();
        step();
        chk("R11 grant not cut by stale done", {12'h0, grant}, 16'h0004);
        acc_done = 1'b1;
        step();
        acc_done = 1'b0;
        req = 4'h0;
    endtask

    initial begin
        rst = 1'b1;
        req = 4'h0;
        acc_done = 1'b0;
        cfg_wr_en = 1'b0;
        cfg_wr_data = 16'h0;
        step();
        step();
        rst = 1'b0;
        step();
        t_reset();
        t_default_order();
        t_hold();
        t_program();
        t_dup();
        t_unnamed();
        t_midwrite();
        t_idle_done();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule